// File: doc/BRIEF.md
# Translation Table Update Engine

This block owns a small array of 64-bit translation entries and carries out update commands against it. A command names a bus address. The engine drops the low page-offset bits of that address, subtracts the window base, and shifts right by the page size to pick an entry. There are four commands:

- **single put** writes one entry;
- **read-back** returns one entry;
- **fill** writes one value into a run of consecutive pages;
- **stream load** takes a run of entries from a valid/ready source and writes them into consecutive pages.

Each successful entry write raises a one-cycle invalidate notification. It carries:

- the page-aligned address relative to the window base;
- the page-masked entry;
- the offset mask;
- the 2-bit permission held in the entry.

Each command ends with a one-cycle completion pulse that carries a status: success, or parameter error.

Single put and read-back complete one cycle after acceptance. Fill and stream load are multi-cycle loops. They hold the engine busy and step the address by one page each time they write. They stop at the first page that falls outside the table. Argument checks reject a bad command before any entry is touched. Looking up which table a command targets, and fetching the stream from memory, are handled outside this block.

Top module: `tte_engine`

## Requirements
- R1: After reset, busy, done_valid, ntf_valid and src_ready are low, and every entry reads back as zero.
- R2: The low PAGE_SHIFT bits of cmd_addr are ignored: the same page is selected whatever their value.
- R3: Entry index = ((cmd_addr with low PAGE_SHIFT bits cleared) − BUS_OFFSET) >> PAGE_SHIFT, computed modulo 2^ADDR_W. An index ≥ ENTRIES yields status 1, writes nothing and raises no notification.
- R4: A read-back (cmd_op=1) returns the stored entry unchanged with status 0. On a bounds error it returns status 1 with done_entry zero.
- R5: Each entry write raises ntf_valid for one cycle with the following fields:
  - ntf_iova = page-aligned relative address;
  - ntf_xlat = entry with its low PAGE_SHIFT bits cleared;
  - ntf_mask = 2^PAGE_SHIFT − 1;
  - ntf_perm = entry bits [1:0].
- R6: A fill (cmd_op=2) is rejected with status 1 and no write when cmd_count is 0 or greater than ENTRIES. Otherwise it writes cmd_value into cmd_count consecutive pages.
- R7: A stream load (cmd_op=3) is rejected with status 1 in three cases, consuming no beat and writing nothing:
  - cmd_count is 0;
  - cmd_count is greater than MAX_STREAM (512);
  - cmd_list_addr has any of its low LIST_ALIGN_SHIFT (12) bits set.
- R8: Each stream beat is a big-endian 64-bit entry: src_data[8*i+7:8*i] is byte i of the list, and byte 0 is the most significant byte of the entry.
- R9: A fill or stream load stops at the first page out of range and reports status 1. Earlier pages stay written and later pages are not touched. In a stream load the failing beat is consumed.
- R10: busy stays high from acceptance of a fill or stream load until the cycle its completion pulse appears. cmd_valid is ignored while busy is high.
- R11: At most one entry is written per cycle. A fill writes one page in each cycle after acceptance. A stream load writes only on a cycle where src_valid and src_ready are both high, and src_ready is high only during a stream load.
- R12: Status is 0 for success and 1 for parameter error. Put (cmd_op=0), read-back and rejected commands complete one cycle after acceptance. A loop completes in the cycle after its final write or failing step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_op | input | 2 | 0 put, 1 read-back, 2 fill, 3 stream load |
| cmd_addr | input | ADDR_W | Bus address of the first page |
| cmd_value | input | 64 | Entry for put and fill |
| cmd_list_addr | input | ADDR_W | Stream list address, checked for alignment |
| cmd_count | input | CNT_W | Page count for fill and stream load |
| busy | output | 1 | A loop command is in progress |
| src_valid | input | 1 | Stream beat available |
| src_data | input | 64 | Stream beat, big-endian byte order |
| src_ready | output | 1 | Beat taken on this cycle when valid |
| done_valid | output | 1 | Completion pulse |
| done_status | output | 1 | 0 success, 1 parameter error |
| done_entry | output | 64 | Read-back result |
| ntf_valid | output | 1 | Invalidate notification pulse |
| ntf_iova | output | ADDR_W | Page-aligned relative bus address |
| ntf_xlat | output | 64 | Page-masked entry |
| ntf_mask | output | ADDR_W | Page offset mask |
| ntf_perm | output | 2 | Entry permission bits |

## Verification
The hardest case to reach is a loop that runs off the end of the table partway through. To get it, the first page must lie inside the window and the count must carry the walk past the last entry. In a stream load, the source must also be delivering beats with gaps while this happens. The directed part of the stimulus starts fills and stream loads two pages below the end, and a random phase sweeps start pages past the table and counts up to beyond its size, with a randomly gapped source. A command presented while a loop is busy is followed by a read-back of the page that command targeted.

// File: rtl/tte_pkg.sv
package tte_pkg;
    typedef enum logic [1:0] {
        OP_PUT    = 2'd0,
        OP_GET    = 2'd1,
        OP_FILL   = 2'd2,
        OP_STREAM = 2'd3
    } tte_op_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FILL   = 2'd1,
        S_STREAM = 2'd2
    } tte_state_e;

    localparam logic STAT_OK  = 1'b0;
    localparam logic STAT_BAD = 1'b1;

    typedef logic [63:0] tte_entry_t;
endpackage

// File: rtl/tte_index.sv
// Maps a raw bus address to a table slot and a relative page address.
module tte_index #(
    parameter int          ADDR_W     = 32,
    parameter int          PAGE_SHIFT = 12,
    parameter int unsigned BUS_OFFSET = 32'h0010_0000,
    parameter int          ENTRIES    = 16,
    parameter int          IDX_W      = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] rel_page,
    output logic [IDX_W-1:0]  idx,
    output logic              in_range
);
    localparam logic [ADDR_W-1:0] PG_MASK = ~((ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1));

    logic [ADDR_W-1:0] page_num;

    always_comb begin
        rel_page = (addr & PG_MASK) - ADDR_W'(BUS_OFFSET);
        page_num = rel_page >> PAGE_SHIFT;
        in_range = page_num < ADDR_W'(ENTRIES);
        idx      = page_num[IDX_W-1:0];
    end
endmodule

// File: rtl/tte_bswap.sv
// Reverses byte order of a stream beat.
module tte_bswap #(
    parameter int BYTES = 8
) (
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign dout[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
    end
endmodule

// File: rtl/tte_ntf_fmt.sv
// Splits an entry into its page-masked address and permission.
module tte_ntf_fmt #(
    parameter int PAGE_SHIFT = 12
) (
    input  tte_pkg::tte_entry_t entry,
    output tte_pkg::tte_entry_t xlat,
    output logic [1:0]          perm
);
    localparam tte_pkg::tte_entry_t LOW_MASK = (64'd1 << PAGE_SHIFT) - 64'd1;

    assign xlat = entry & ~LOW_MASK;
    assign perm = entry[1:0];
endmodule

// File: rtl/tte_engine.sv
module tte_engine
    import tte_pkg::*;
#(
    parameter int          ADDR_W           = 32,
    parameter int          PAGE_SHIFT       = 12,
    parameter int unsigned BUS_OFFSET       = 32'h0010_0000,
    parameter int          ENTRIES          = 16,
    parameter int          CNT_W            = 11,
    parameter int          MAX_STREAM       = 512,
    parameter int          LIST_ALIGN_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [63:0]       cmd_value,
    input  logic [ADDR_W-1:0] cmd_list_addr,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic              busy,
    input  logic              src_valid,
    input  logic [63:0]       src_data,
    output logic              src_ready,
    output logic              done_valid,
    output logic              done_status,
    output logic [63:0]       done_entry,
    output logic              ntf_valid,
    output logic [ADDR_W-1:0] ntf_iova,
    output logic [63:0]       ntf_xlat,
    output logic [ADDR_W-1:0] ntf_mask,
    output logic [1:0]        ntf_perm
);
    localparam int                IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [ADDR_W-1:0] PG_BYTES  = ADDR_W'(1) << PAGE_SHIFT;
    localparam logic [ADDR_W-1:0] OFF_MASK  = PG_BYTES - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] LIST_MASK = (ADDR_W'(1) << LIST_ALIGN_SHIFT) - ADDR_W'(1);

    typedef struct packed {
        tte_state_e        state;
        logic [ADDR_W-1:0] cur;
        logic [CNT_W-1:0]  left;
        tte_entry_t        value;
        logic              done_v;
        logic              done_s;
        tte_entry_t        done_e;
        logic              ntf_v;
        logic [ADDR_W-1:0] ntf_iova;
        tte_entry_t        ntf_xlat;
        logic [1:0]        ntf_perm;
    } regs_t;

    regs_t r_q, r_d;

    tte_entry_t        tbl_q [ENTRIES];
    logic              wr_en;
    tte_entry_t        wr_data;
    tte_entry_t        beat_entry;
    tte_entry_t        fmt_xlat;
    logic [1:0]        fmt_perm;
    logic [ADDR_W-1:0] sel_addr;
    logic [ADDR_W-1:0] rel_page;
    logic [IDX_W-1:0]  idx;
    logic              in_range;
    logic              idle;
    tte_op_e           op;

    assign idle     = (r_q.state == S_IDLE);
    assign op       = tte_op_e'(cmd_op);
    assign sel_addr = idle ? cmd_addr : r_q.cur;

    tte_index #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .BUS_OFFSET(BUS_OFFSET),
        .ENTRIES(ENTRIES), .IDX_W(IDX_W)
    ) u_index (
        .addr(sel_addr), .rel_page(rel_page), .idx(idx), .in_range(in_range)
    );

    tte_bswap #(.BYTES(8)) u_bswap (.din(src_data), .dout(beat_entry));

    always_comb begin
        if (idle)                     wr_data = cmd_value;
        else if (r_q.state == S_FILL) wr_data = r_q.value;
        else                          wr_data = beat_entry;
    end

    tte_ntf_fmt #(.PAGE_SHIFT(PAGE_SHIFT)) u_fmt (
        .entry(wr_data), .xlat(fmt_xlat), .perm(fmt_perm)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done_v = 1'b0;
        r_d.ntf_v  = 1'b0;
        wr_en    = 1'b0;
        unique case (r_q.state)
            S_IDLE: begin
                if (cmd_valid) begin
                    unique case (op)
                        OP_PUT: begin
                            r_d.done_v = 1'b1;
                            r_d.done_e = '0;
                            r_d.done_s = in_range ? STAT_OK : STAT_BAD;
                            if (in_range) begin
                                wr_en        = 1'b1;
                                r_d.ntf_v    = 1'b1;
                                r_d.ntf_iova = rel_page;
                                r_d.ntf_xlat = fmt_xlat;
                                r_d.ntf_perm = fmt_perm;
                            end
                        end
                        OP_GET: begin
                            r_d.done_v = 1'b1;
                            r_d.done_s = in_range ? STAT_OK : STAT_BAD;
                            r_d.done_e = in_range ? tbl_q[idx] : '0;
                        end
                        OP_FILL: begin
                            if (cmd_count == '0 || cmd_count > CNT_W'(ENTRIES)) begin
                                r_d.done_v = 1'b1;
                                r_d.done_s = STAT_BAD;
                                r_d.done_e = '0;
                            end else begin
                                r_d.state = S_FILL;
                                r_d.cur   = cmd_addr & ~OFF_MASK;
                                r_d.left  = cmd_count;
                                r_d.value = cmd_value;
                            end
                        end
                        default: begin
                            if (cmd_count == '0 || cmd_count > CNT_W'(MAX_STREAM) ||
                                (cmd_list_addr & LIST_MASK) != '0) begin
                                r_d.done_v = 1'b1;
                                r_d.done_s = STAT_BAD;
                                r_d.done_e = '0;
                            end else begin
                                r_d.state = S_STREAM;
                                r_d.cur   = cmd_addr & ~OFF_MASK;
                                r_d.left  = cmd_count;
                            end
                        end
                    endcase
                end
            end
            default: begin
                if (r_q.state == S_FILL || src_valid) begin
                    if (in_range) begin
                        wr_en        = 1'b1;
                        r_d.ntf_v    = 1'b1;
                        r_d.ntf_iova = rel_page;
                        r_d.ntf_xlat = fmt_xlat;
                        r_d.ntf_perm = fmt_perm;
                        r_d.cur      = r_q.cur + PG_BYTES;
                        r_d.left     = r_q.left - CNT_W'(1);
                        if (r_q.left == CNT_W'(1)) begin
                            r_d.state  = S_IDLE;
                            r_d.done_v = 1'b1;
                            r_d.done_s = STAT_OK;
                            r_d.done_e = '0;
                        end
                    end else begin
                        r_d.state  = S_IDLE;
                        r_d.done_v = 1'b1;
                        r_d.done_s = STAT_BAD;
                        r_d.done_e = '0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
        end else if (wr_en) begin
            tbl_q[idx] <= wr_data;
        end
    end

    assign busy        = !idle;
    assign src_ready   = (r_q.state == S_STREAM);
    assign done_valid  = r_q.done_v;
    assign done_status = r_q.done_s;
    assign done_entry  = r_q.done_e;
    assign ntf_valid   = r_q.ntf_v;
    assign ntf_iova    = r_q.ntf_iova;
    assign ntf_xlat    = r_q.ntf_xlat;
    assign ntf_mask    = OFF_MASK;
    assign ntf_perm    = r_q.ntf_perm;

    // R10
    busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done_valid));

    // R3
    err_no_ntf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_status) |-> !ntf_valid);

    // R5
    iova_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> ((ntf_iova & OFF_MASK) == '0));

    // R5
    xlat_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> (ntf_xlat[PAGE_SHIFT-1:0] == '0));

    // R11
    stall_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ready && !src_valid) |=> !ntf_valid);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid) |=> (!done_valid && !ntf_valid));
endmodule

// File: tb/tb_tte_engine.sv
module tb_tte_engine;
    import tte_pkg::*;

    localparam int          CLK_PERIOD = 10;
    localparam int          ENT        = 16;
    localparam int          PSH        = 12;
    localparam logic [31:0] OFF        = 32'h0010_0000;
    localparam logic [31:0] PG         = 32'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [31:0] cmd_addr = '0;
    logic [63:0] cmd_value = '0;
    logic [31:0] cmd_list_addr = '0;
    logic [10:0] cmd_count = '0;
    logic        busy;
    logic        src_valid = 1'b0;
    logic [63:0] src_data = '0;
    logic        src_ready;
    logic        done_valid, done_status;
    logic [63:0] done_entry;
    logic        ntf_valid;
    logic [31:0] ntf_iova;
    logic [63:0] ntf_xlat;
    logic [31:0] ntf_mask;
    logic [1:0]  ntf_perm;

    tte_engine dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_value(cmd_value), .cmd_list_addr(cmd_list_addr),
        .cmd_count(cmd_count), .busy(busy), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .done_valid(done_valid), .done_status(done_status),
        .done_entry(done_entry), .ntf_valid(ntf_valid), .ntf_iova(ntf_iova),
        .ntf_xlat(ntf_xlat), .ntf_mask(ntf_mask), .ntf_perm(ntf_perm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] mdl [ENT];
    logic [63:0] svals [600];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rel_of(input logic [31:0] a);
        return (a & ~(PG - 1)) - OFF;
    endfunction
    function automatic bit inb(input logic [31:0] a);
        return (rel_of(a) >> PSH) < ENT;
    endfunction
    function automatic int idx_of(input logic [31:0] a);
        return int'(rel_of(a) >> PSH);
    endfunction
    function automatic logic [63:0] to_beat(input logic [63:0] v);
        logic [63:0] o;
        for (int i = 0; i < 8; i++) o[8*i +: 8] = v[63-8*i -: 8];
        return o;
    endfunction

    task automatic run_cmd(input logic [1:0] op, input logic [31:0] addr, input logic [63:0] val,
                           input logic [31:0] lst, input int cnt, input bit intrude, input string tag);
        bit reject, exp_err, single;
        int nwr, exp_cyc, seen, ptr, cyc;
        logic [63:0] exp_data;
        logic [31:0] base;
        bit pv, pr;
        base = addr & ~(PG - 1);
        single = (op == OP_PUT) || (op == OP_GET);
        reject = (op == OP_FILL && (cnt == 0 || cnt > ENT)) ||
                 (op == OP_STREAM && (cnt == 0 || cnt > 512 || lst[11:0] != 0));
        exp_data = '0;
        nwr = 0;
        if (single) begin
            exp_err = !inb(addr);
            nwr = (op == OP_PUT && !exp_err) ? 1 : 0;
            if (op == OP_GET && !exp_err) exp_data = mdl[idx_of(addr)];
            exp_cyc = 1;
        end else if (reject) begin
            exp_err = 1;
            exp_cyc = 1;
        end else begin
            while (nwr < cnt && inb(base + PG * nwr)) nwr++;
            exp_err = (nwr < cnt);
            exp_cyc = exp_err ? nwr + 2 : nwr + 1;
        end
        for (int k = 0; k < cnt && k < 600; k++) svals[k] = {$urandom, $urandom};
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_value = val;
        cmd_list_addr = lst; cmd_count = 11'(cnt);
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 1; seen = 0; ptr = 0; pv = 0; pr = 0;
        forever begin
            if (pv && pr) ptr++;
            if (ntf_valid) begin
                logic [63:0] e;
                logic [31:0] a;
                a = base + PG * seen;
                e = (op == OP_STREAM) ? svals[seen] : val;
                chk(ntf_iova == rel_of(a), "R5 iova", 64'(ntf_iova), 64'(rel_of(a)));
                chk(ntf_xlat == (e & ~64'hFFF), (op == OP_STREAM) ? "R8 xlat" : "R5 xlat",
                    ntf_xlat, e & ~64'hFFF);
                chk(ntf_perm == e[1:0], "R5 perm", 64'(ntf_perm), 64'(e[1:0]));
                chk(ntf_mask == PG - 1, "R5 mask", 64'(ntf_mask), 64'(PG - 1));
                if (inb(a)) mdl[idx_of(a)] = e;
                seen++;
            end
            if (done_valid) begin
                chk(done_status == exp_err, tag, 64'(done_status), 64'(exp_err));
                chk(seen == nwr, "R9 write count", 64'(seen), 64'(nwr));
                if (op == OP_GET) chk(done_entry == exp_data, "R4 entry", done_entry, exp_data);
                if (op != OP_STREAM) chk(cyc == exp_cyc, "R12/R11 latency", 64'(cyc), 64'(exp_cyc));
                chk(!busy, "R10 busy clear", 64'(busy), 64'd0);
                break;
            end
            chk(busy, "R10 busy held", 64'(busy), 64'd1);
            if (intrude && cyc == 1) begin
                cmd_valid = 1'b1; cmd_op = OP_PUT;
                cmd_addr = OFF + PG * (ENT - 1); cmd_value = 64'hFFFF_FFFF_FFFF_FFFF;
            end else begin
                cmd_valid = 1'b0;
            end
            if (op == OP_STREAM) begin
                src_valid = ($urandom % 3) != 0;
                src_data = to_beat(svals[ptr < 600 ? ptr : 0]);
                pv = src_valid;
                pr = src_ready;
            end else begin
                src_valid = 1'b0;
                pv = 0;
            end
            @(negedge clk);
            cyc++;
            if (cyc > 3000) begin
                chk(0, "R12 no completion", 64'(cyc), 64'(exp_cyc));
                break;
            end
        end
        src_valid = 1'b0;
        cmd_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < ENT; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done_valid && !ntf_valid && !src_ready, "R1 outputs idle",
            {60'd0, busy, done_valid, ntf_valid, src_ready}, 64'd0);
        for (int i = 0; i < ENT; i++) run_cmd(OP_GET, OFF + PG * i, 0, 0, 0, 0, "R1 read zero");

        // R2 low bits ignored, R4 read back
        run_cmd(OP_PUT, OFF + PG * 3 + 32'hABC, 64'h1234_5678_9ABC_DEF3, 0, 0, 0, "R2 put");
        run_cmd(OP_GET, OFF + PG * 3 + 32'h007, 0, 0, 0, 0, "R4 get");
        // R3 bounds
        run_cmd(OP_PUT, OFF - PG, 64'h55, 0, 0, 0, "R3 below window");
        run_cmd(OP_PUT, OFF + PG * ENT, 64'h55, 0, 0, 0, "R3 past end");
        run_cmd(OP_GET, OFF + PG * ENT, 0, 0, 0, 0, "R4 get error");
        // R6 fill
        run_cmd(OP_FILL, OFF, 64'hAAAA_0000_0000_1002, 0, ENT, 0, "R6 full fill");
        run_cmd(OP_FILL, OFF, 64'h77, 0, ENT + 1, 0, "R6 count too big");
        run_cmd(OP_FILL, OFF, 64'h77, 0, 0, 0, "R6 count zero");
        run_cmd(OP_GET, OFF, 0, 0, 0, 0, "R6 untouched after reject");
        // R9 fill crossing end
        run_cmd(OP_FILL, OFF + PG * (ENT - 2), 64'hBEEF_0001, 0, 4, 0, "R9 fill stop");
        // R7 stream rejects
        run_cmd(OP_STREAM, OFF, 0, 32'h8000, 513, 0, "R7 count over");
        run_cmd(OP_STREAM, OFF, 0, 32'h8008, 2, 0, "R7 list misaligned");
        run_cmd(OP_STREAM, OFF, 0, 32'h8000, 0, 0, "R7 count zero");
        run_cmd(OP_GET, OFF + PG, 0, 0, 0, 0, "R7 untouched");
        // R8 stream byte order
        run_cmd(OP_STREAM, OFF + PG * 2, 0, 32'h4000, 5, 0, "R8 stream");
        for (int i = 2; i < 7; i++) run_cmd(OP_GET, OFF + PG * i, 0, 0, 0, 0, "R8 readback");
        // R9 stream crossing end
        run_cmd(OP_STREAM, OFF + PG * (ENT - 2), 0, 32'h0, 5, 0, "R9 stream stop");
        // R10 command during busy is ignored
        run_cmd(OP_FILL, OFF, 64'h0F0F_0000, 0, 4, 1, "R10 fill with intrusion");
        run_cmd(OP_GET, OFF + PG * (ENT - 1), 0, 0, 0, 0, "R10 intruder ignored");

        // random phase
        for (int n = 0; n < 250; n++) begin
            logic [1:0]  op;
            logic [31:0] a;
            logic [31:0] l;
            int c;
            op = 2'($urandom % 4);
            a = OFF + PG * ($urandom % (ENT + 4)) + ($urandom % 4096);
            if ($urandom % 8 == 0) a = $urandom;
            c = $urandom % (ENT + 3);
            l = ($urandom % 16 == 0) ? 32'h0000_1010 : 32'h0002_0000;
            if (op == OP_STREAM && $urandom % 16 == 0) c = 513 + $urandom % 8;
            run_cmd(op, a, {$urandom, $urandom}, l, c, 0, "R12 random status");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule